// File: doc/BRIEF.md
# Serial-Bus Wiper Position Slave

This block is a two-wire serial-bus slave that owns the six-bit position register of a 64-step potentiometer. A fast system clock oversamples the bus clock and data lines. The block recognises bus start and stop events from the sampled lines and decodes a seven-bit device address. The lowest address bit comes from a strap pin, so two of these devices can share one bus. The block only ever pulls the data line low, through an output-enable, so the line stays open-drain.

A write transfer carries three bytes: the address byte, a command byte and a value byte. The top bit of the command byte asks for the value to be made permanent. When that request completes, the position register freezes and a programmed flag is raised. A read transfer returns a single byte straight after the address acknowledge. That byte holds the two programmed-status bits above the current position. The master closes a read with a not-acknowledge followed by a stop.

Top module: `wiper_i2c_slave`

## Requirements
- R1: A data-line fall while the clock line is high is a start. From any state, a start restarts address reception. A data-line rise while the clock line is high is a stop. A stop returns the slave to idle with the data line released.
- R2: The address byte is {0,1,0,1,1,0, strap_a0_i, rw}, sent MSB first. On a match, the slave pulls the data line low (sda_oe_o = 1) for the whole ninth clock pulse.
- R3: On an address mismatch, the slave does not acknowledge. It keeps the data line released for all later bytes until the next start.
- R4: The slave changes sda_oe_o only while the bus clock is low, and never during a clock-high period.
- R5: In a write (rw = 0), the slave acknowledges the command byte and the value byte. wiper_o then takes bits 5:0 of the value byte, and bits 7:6 have no effect.
- R6: wiper_o changes only after the acknowledge pulse of the value byte ends. A stop or start before that point leaves wiper_o unchanged.
- R7: In a read (rw = 1), the slave drives the byte {s1, s0, wiper_o} MSB first right after the address acknowledge. It then releases the line for the master's not-acknowledge.
- R8: A write whose command byte has bit 7 set raises locked_o when it completes. From then on, the status bits s1 s0 read as 11 instead of 00.
- R9: While locked_o is high, later writes are still acknowledged, but wiper_o does not change.
- R10: After reset, wiper_o is 32, locked_o is 0 and sda_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_a0_i | input | 1 | Strapped low address bit |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| wiper_o | output | 6 | Current wiper position |
| locked_o | output | 1 | Permanent-programming flag |

## Verification
A wrong frame state shows up at the very next acknowledge slot. The slave either fails to pull the line low on the ninth pulse or pulls it low when it should not, and the master samples that half a bus-clock later. A shift or bit-count error corrupts the read byte, or it puts the wiper update on the wrong byte. Reading back after every write exposes either fault within one transfer. A lock flag that is wrong shows in the next read, through the status bits, and in the next write, which should leave the wiper as it was.

// File: rtl/wip_pkg.sv
package wip_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INSTR,
    ST_INSTR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_DONE
  } frame_st_t;

endpackage

// File: rtl/wip_line_sync.sv
module wip_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] pipe_q [STAGES];
  logic [1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q[0] <= 2'b11;
    else        pipe_q[0] <= {scl_i, sda_i};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= 2'b11;
      else        pipe_q[g] <= pipe_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b11;
    else        prev_q <= pipe_q[STAGES-1];
  end

  assign scl_s     = pipe_q[STAGES-1][1];
  assign sda_s     = pipe_q[STAGES-1][0];
  assign scl_rise  = scl_s & ~prev_q[1];
  assign scl_fall  = ~scl_s & prev_q[1];
  assign start_det = scl_s & prev_q[1] & prev_q[0] & ~sda_s;
  assign stop_det  = scl_s & prev_q[1] & ~prev_q[0] & sda_s;

endmodule

// File: rtl/wip_frame_fsm.sv
module wip_frame_fsm
  import wip_pkg::*;
#(
  parameter int                 DATA_W    = 8,
  parameter int                 VAL_W     = 6,
  parameter int                 ADDR_HI_W = 6,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 6'b010110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              strap_a0,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              sda_oe,
  output logic              commit,
  output logic [VAL_W-1:0]  commit_val,
  output logic              commit_otp
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  frame_st_t         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic              rw_q, rw_d;
  logic              otp_q, otp_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    otp_d   = otp_q;
    commit  = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_ADDR, ST_INSTR, ST_DATA: begin
          if (scl_rise) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[DATA_W-1:1] == {ADDR_HI, strap_a0}) begin
                rw_d    = sh_q[0];
                state_d = ST_ADDR_ACK;
              end else begin
                state_d = ST_DONE;
              end
            end else if (state_q == ST_INSTR) begin
              otp_d   = sh_q[DATA_W-1];
              state_d = ST_INSTR_ACK;
            end else begin
              state_d = ST_DATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              tx_d    = tx_byte;
              state_d = ST_RD_BYTE;
            end else begin
              state_d = ST_INSTR;
            end
          end
        end
        ST_INSTR_ACK: begin
          if (scl_fall) state_d = ST_DATA;
        end
        ST_DATA_ACK: begin
          if (scl_fall) begin
            commit  = 1'b1;
            state_d = ST_DONE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            tx_d  = {tx_q[DATA_W-2:0], 1'b0};
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
              cnt_d   = '0;
              state_d = ST_RD_ACK;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_fall) state_d = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      otp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      rw_q    <= rw_d;
      otp_q   <= otp_d;
    end
  end

  assign sda_oe = (state_q == ST_ADDR_ACK) || (state_q == ST_INSTR_ACK) ||
                  (state_q == ST_DATA_ACK) ||
                  ((state_q == ST_RD_BYTE) && !tx_q[DATA_W-1]);
  assign commit_val = sh_q[VAL_W-1:0];
  assign commit_otp = otp_q;

  // R4: the pull-down only moves while the sampled bus clock is low
  a_r4_oe_moves_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R1: a stop always leaves the data line released
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R6: an update request appears only as a clock-low event
  a_r6_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !scl_s);

endmodule

// File: rtl/wip_store.sv
module wip_store #(
  parameter int               VAL_W     = 6,
  parameter logic [VAL_W-1:0] RESET_VAL = 6'd32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [VAL_W-1:0] commit_val,
  input  logic             commit_otp,
  output logic [VAL_W-1:0] wiper,
  output logic             locked
);

  logic [VAL_W-1:0] wiper_q, wiper_d;
  logic             lock_q, lock_d;
  logic             wr_en;

  assign wr_en = commit & ~lock_q;

  always_comb begin
    wiper_d = wiper_q;
    lock_d  = lock_q;
    if (wr_en) begin
      wiper_d = commit_val;
      lock_d  = commit_otp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= RESET_VAL;
      lock_q  <= 1'b0;
    end else begin
      wiper_q <= wiper_d;
      lock_q  <= lock_d;
    end
  end

  assign wiper  = wiper_q;
  assign locked = lock_q;

  // R8: once programmed, the flag stays set until reset
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R9: an update request while locked leaves the position alone
  a_r9_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && lock_q) |=> $stable(wiper_q));

  // R6: the position moves only in the cycle after an update request
  a_r6_update_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_q) |-> $past(commit));

endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int VAL_W       = 6
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             strap_a0_i,
  output logic             sda_oe_o,
  output logic [VAL_W-1:0] wiper_o,
  output logic             locked_o
);

  localparam int STAT_W = DATA_W - VAL_W;
  localparam logic [VAL_W-1:0] MID_VAL = VAL_W'(1 << (VAL_W - 1));

  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic commit, commit_otp;
  logic [VAL_W-1:0]  commit_val;
  logic [DATA_W-1:0] tx_byte;

  wip_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign tx_byte = {{STAT_W{locked_o}}, wiper_o};

  wip_frame_fsm #(.DATA_W(DATA_W), .VAL_W(VAL_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .strap_a0   (strap_a0_i),
    .tx_byte    (tx_byte),
    .sda_oe     (sda_oe_o),
    .commit     (commit),
    .commit_val (commit_val),
    .commit_otp (commit_otp)
  );

  wip_store #(.VAL_W(VAL_W), .RESET_VAL(MID_VAL)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .commit_val (commit_val),
    .commit_otp (commit_otp),
    .wiper      (wiper_o),
    .locked     (locked_o)
  );

endmodule

// File: tb/test_wiper_i2c_slave.sv
module test_wiper_i2c_slave;

  localparam int Q = 20;

  typedef struct {
    string tag;
    int    val;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni;
  logic m_scl, m_sda, strap;
  logic sda_oe;
  logic [5:0] wiper;
  logic locked;
  logic sda_bus;

  int errors = 0;
  int checks = 0;
  int viol   = 0;
  bit done   = 1'b0;

  item_t exp_q[$];
  item_t obs_q[$];

  always #2.5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  wiper_i2c_slave i_wiper_i2c_slave (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .scl_i      (m_scl),
    .sda_i      (sda_bus),
    .strap_a0_i (strap),
    .sda_oe_o   (sda_oe),
    .wiper_o    (wiper),
    .locked_o   (locked)
  );

  // monitor: pops expected and observed items and compares them
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        item_t e;
        item_t o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        checks++;
        if (e.val != o.val) begin
          errors++;
          $display("FAIL %s: actual=0x%0h expected=0x%0h", e.tag, o.val, e.val);
        end
      end
    end
  end

  // R4 watcher: no pull-down change during a clock-high period
  logic prev_scl, prev_oe;
  always @(negedge clk) begin
    if (rst_ni && m_scl && prev_scl && (sda_oe !== prev_oe)) viol++;
    prev_scl <= m_scl;
    prev_oe  <= sda_oe;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic check_now(string tag, int e, int o);
    exp_q.push_back('{tag, e});
    obs_q.push_back('{tag, o});
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic bit_out(logic b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    @(negedge clk);
    b = sda_bus;
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic tx_checked(string tag, logic [7:0] b, logic exp_ack);
    logic a;
    exp_q.push_back('{tag, int'(exp_ack)});
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(a);
    obs_q.push_back('{tag, int'(a)});
  endtask

  task automatic rx_checked(string tag, logic [7:0] exp_b);
    logic [7:0] b;
    exp_q.push_back('{tag, int'(exp_b)});
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(1'b1);
    obs_q.push_back('{tag, int'(b)});
  endtask

  task automatic settle_check_wiper(string tag, int e);
    tick(10);
    @(negedge clk);
    check_now(tag, e, int'(wiper));
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          errors++;
          checks++;
          $display("FAIL watchdog (R1..all): actual=timeout expected=finish");
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none

    rst_ni = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 1'b0;
    tick(5);
    @(negedge clk);
    check_now("R10 oe in reset", 0, int'(sda_oe));
    rst_ni = 1'b1;
    tick(10);
    @(negedge clk);
    check_now("R10 wiper reset", 32, int'(wiper));
    check_now("R10 locked reset", 0, int'(locked));

    // R5: plain write, top two value bits ignored
    bus_start();
    tx_checked("R2 write addr ack", 8'h58, 1'b0);
    tx_checked("R5 command ack", 8'h00, 1'b0);
    tx_checked("R5 value ack", 8'hD5, 1'b0);
    bus_stop();
    settle_check_wiper("R5 wiper from low bits", 'h15);

    // R7: read back with status 00
    bus_start();
    tx_checked("R2 read addr ack", 8'h59, 1'b0);
    rx_checked("R7 read byte", 8'h15);
    bus_stop();
    tick(4);
    @(negedge clk);
    check_now("R7 released after read", 0, int'(sda_oe));

    // R3: strap bit mismatch
    bus_start();
    tx_checked("R3 mismatch no ack", 8'h5A, 1'b1);
    tx_checked("R3 stays released", 8'h00, 1'b1);
    bus_stop();
    settle_check_wiper("R3 wiper untouched", 'h15);

    // R6: stop in the middle of the value byte
    bus_start();
    tx_checked("R6 addr ack", 8'h58, 1'b0);
    tx_checked("R6 command ack", 8'h00, 1'b0);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop();
    settle_check_wiper("R6 stop abort keeps wiper", 'h15);

    // R1/R6: repeated start in the middle of the value byte
    bus_start();
    tx_checked("R1 addr ack", 8'h58, 1'b0);
    tx_checked("R1 command ack", 8'h00, 1'b0);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    bus_start();
    tx_checked("R1 restart addr ack", 8'h59, 1'b0);
    rx_checked("R6 restart abort keeps wiper", 8'h15);
    bus_stop();

    // R2: strap high moves the address
    strap = 1'b1;
    tick(4);
    bus_start();
    tx_checked("R2 strap1 addr ack", 8'h5A, 1'b0);
    tx_checked("R5 strap1 command ack", 8'h00, 1'b0);
    tx_checked("R5 strap1 value ack", 8'h07, 1'b0);
    bus_stop();
    settle_check_wiper("R5 strap1 wiper", 7);
    bus_start();
    tx_checked("R3 old addr no ack", 8'h58, 1'b1);
    bus_stop();
    strap = 1'b0;
    tick(4);

    // R8: permanent programming
    bus_start();
    tx_checked("R8 addr ack", 8'h58, 1'b0);
    tx_checked("R8 command ack", 8'h80, 1'b0);
    tx_checked("R8 value ack", 8'hEA, 1'b0);
    bus_stop();
    settle_check_wiper("R8 wiper programmed", 'h2A);
    check_now("R8 locked flag", 1, int'(locked));
    bus_start();
    tx_checked("R8 read addr ack", 8'h59, 1'b0);
    rx_checked("R8 status 11 in read", 8'hEA);
    bus_stop();

    // R9: writes after lock acked but ignored
    bus_start();
    tx_checked("R9 addr ack", 8'h58, 1'b0);
    tx_checked("R9 command ack", 8'h00, 1'b0);
    tx_checked("R9 value ack", 8'h11, 1'b0);
    bus_stop();
    settle_check_wiper("R9 wiper frozen", 'h2A);
    bus_start();
    tx_checked("R9 otp addr ack", 8'h58, 1'b0);
    tx_checked("R9 otp command ack", 8'h80, 1'b0);
    tx_checked("R9 otp value ack", 8'h05, 1'b0);
    bus_stop();
    settle_check_wiper("R9 wiper frozen after otp", 'h2A);

    // R10: reset restores midscale
    rst_ni = 1'b0;
    tick(3);
    rst_ni = 1'b1;
    tick(10);
    @(negedge clk);
    check_now("R10 wiper after second reset", 32, int'(wiper));
    check_now("R10 locked after second reset", 0, int'(locked));

    check_now("R4 oe changes during clock high", 0, viol);

    tick(5);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule